// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral has four separate 8-bit down-counters behind a byte-wide register bus. A two-bit select picks the channel. A channel counts one of two things. In event mode it counts edges of its own external trigger input, and the active polarity can be chosen. In interval mode it counts the system clock after a prescaler that divides by 16 or by 256. An interval-mode channel can start as soon as its constant is loaded, or it can wait for a trigger edge.

When a channel reaches the end of its count, it reloads its constant on its own. It also pulses its terminal output for one clock and, if enabled, raises an interrupt request. The terminal outputs can be wired back into the trigger inputs of other channels. Two 8-bit stages then form one 16-bit divider, for example to derive a slow periodic tick.

Software writes an interrupt vector base once. Each channel then presents its own vector slot, and the lowest channel number wins when several channels request at once.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every channel reads 0 and is stopped, no terminal pulse or interrupt is asserted, and the presented vector is 0x00.
- R2: A byte written to a channel with no constant pending is a command when bit 0 is 1. Command bit 2 makes the next byte written to that channel its time constant, whatever its bit 0. Loading a constant into a stopped channel makes a read of that channel return the constant.
- R3: A byte with bit 0 clear, written to channel 0 while channel 0 has no constant pending, becomes the vector base. The same kind of byte written to channels 1 to 3 changes neither the vector nor the count.
- R4: With command bit 6 = 1 (event mode) the counter decrements once per edge of its trigger input. Command bit 4 = 1 selects rising edges and 0 selects falling edges.
- R5: A decrement from a count of 1 reloads the constant, and the channel's terminal output goes high for exactly one clock. A constant of 0 counts 256 decrements.
- R6: With command bit 6 = 0 (interval mode) the counter decrements every 16 clocks when bit 5 = 0 and every 256 clocks when bit 5 = 1. The terminal period is therefore the prescale times the constant.
- R7: In interval mode with command bit 3 = 1, the channel holds its loaded count until a trigger edge of the selected polarity arrives, and then starts.
- R8: A command with bit 1 set stops the channel. Its count stays frozen until a new constant is loaded.
- R9: Command bit 7 lets a terminal event set the channel's request. The vector is base[7:3], then the channel number in bits 2:1, then 0 in bit 0. The lowest-numbered requesting channel is presented. irq_ack clears the presented request. With no request, the vector shows the channel 0 slot.
- R10: When the terminal output of an interval-mode channel drives the trigger of an event-mode channel, the second channel's terminal period is the product of the two divisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Channel select for read and write |
| bus_we | input | 1 | Write strobe, one byte per clock |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Current count of the selected channel |
| trig_in | input | 4 | Asynchronous trigger/event inputs, one per channel |
| zc_pulse | output | 4 | One-clock terminal-count pulses, one per channel |
| irq | output | 1 | Any enabled channel is requesting |
| irq_vec | output | 8 | Vector of the presented channel |
| irq_ack | input | 1 | Clears the request of the presented channel |

## Verification
The hardest state to reach from the ports is a cascade that has settled into a steady ratio. The second channel's trigger never comes from the bench directly, because it comes from the first channel's terminal pulse after the synchronizer delay. The bench routes that pulse back into the next trigger input and measures the spacing between two successive terminal pulses of the second channel. Measuring the spacing makes the result independent of the fixed latency through the synchronizer and the first channel's start phase. Interrupt priority also needs two live requests at once. Two channels are therefore each fired with a single edge and a constant of 1, and are then acknowledged one at a time.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

  // Decoded command fields held by each channel
  typedef struct packed {
    logic irq_en;     // request on terminal count
    logic evt_mode;   // 1: count trigger edges, 0: count prescaled clock
    logic pre_wide;   // 1: divide by the long prescale
    logic rise_edge;  // 1: rising edges are active
    logic wait_trig;  // interval mode: hold until a trigger edge
  } qdt_mode_t;

  function automatic qdt_mode_t qdt_decode(input logic [7:0] cmd);
    qdt_mode_t m;
    m.irq_en    = cmd[7];
    m.evt_mode  = cmd[6];
    m.pre_wide  = cmd[5];
    m.rise_edge = cmd[4];
    m.wait_trig = cmd[3];
    return m;
  endfunction

  // Count after one decrement: reload on leaving 1, so a constant of 0 spans 256
  function automatic logic [7:0] qdt_next_count(input logic [7:0] cur, input logic [7:0] tc);
    return (cur == 8'd1) ? tc : cur - 8'd1;
  endfunction

  // Vector slot for a channel: base upper bits, channel in 2:1, bit 0 low
  function automatic logic [7:0] qdt_vector(input logic [7:0] base, input logic [1:0] ch);
    return {base[7:3], ch, 1'b0};
  endfunction

endpackage

// File: rtl/qdt_trig_sync.sv
module qdt_trig_sync #(
  parameter int N_CH   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] trig_async,
  output logic [N_CH-1:0] trig_rise,
  output logic [N_CH-1:0] trig_fall
);
  localparam int SH_W = STAGES + 1;

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    logic [SH_W-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], trig_async[g]};
    end
    assign trig_rise[g] =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign trig_fall[g] = ~sh_q[STAGES-1] &  sh_q[STAGES];
  end
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              trig_rise,
  input  logic              trig_fall,
  input  logic              ack,
  output logic [DATA_W-1:0] count_o,
  output logic              zc_o,
  output logic              req_o,
  output logic              run_o,
  output logic              tc_pend_o
);
  localparam int PW = $clog2(PRE_HI);

  qdt_mode_t         mode_q;
  logic              run_q, armed_q, pend_q, zc_q, req_q;
  logic [DATA_W-1:0] tc_q, cnt_q;
  logic [PW-1:0]     pre_q;

  logic          is_cmd, is_tc, act_edge, pre_wrap, tick, hit_zero;
  logic [PW-1:0] pre_last;

  always_comb begin
    is_cmd   = wr_stb && !pend_q && wr_byte[0];
    is_tc    = wr_stb && pend_q;
    act_edge = mode_q.rise_edge ? trig_rise : trig_fall;
    pre_last = mode_q.pre_wide ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
    pre_wrap = (pre_q == pre_last);
    tick     = run_q && (mode_q.evt_mode ? act_edge : pre_wrap);
    hit_zero = tick && (cnt_q == DATA_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      zc_q    <= 1'b0;
      req_q   <= 1'b0;
      tc_q    <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      zc_q <= hit_zero;
      // counting path
      if (armed_q && act_edge) begin
        armed_q <= 1'b0;
        run_q   <= 1'b1;
        pre_q   <= '0;
      end else if (run_q && !mode_q.evt_mode) begin
        pre_q <= pre_wrap ? '0 : pre_q + PW'(1);
      end
      if (tick) cnt_q <= qdt_next_count(cnt_q, tc_q);
      // request: acknowledge clears, a new terminal event wins
      if (ack) req_q <= 1'b0;
      if (hit_zero && mode_q.irq_en) req_q <= 1'b1;
      // register writes override the counting path
      if (is_cmd) begin
        mode_q <= qdt_decode(wr_byte);
        pend_q <= wr_byte[2];
        if (wr_byte[1]) begin
          run_q   <= 1'b0;
          armed_q <= 1'b0;
          req_q   <= 1'b0;
        end
      end else if (is_tc) begin
        pend_q <= 1'b0;
        tc_q   <= wr_byte;
        if (!run_q) begin
          cnt_q <= wr_byte;
          pre_q <= '0;
          if (mode_q.evt_mode || !mode_q.wait_trig) begin
            run_q   <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            armed_q <= 1'b1;
          end
        end
      end
    end
  end

  assign count_o   = cnt_q;
  assign zc_o      = zc_q;
  assign req_o     = req_q;
  assign run_o     = run_q;
  assign tc_pend_o = pend_q;
endmodule

// File: rtl/qdt_irq_arb.sv
module qdt_irq_arb
  import qdt_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_CH-1:0]  req,
  input  logic [7:0]       base,
  output logic             irq,
  output logic [SEL_W-1:0] win,
  output logic [7:0]       vec
);
  always_comb begin
    win = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req[i]) win = SEL_W'(i);
    end
    irq = |req;
    vec = qdt_vector(base, win);
  end
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LO      = 16,
  parameter int PRE_HI      = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CH-1:0]   trig_in,
  output logic [N_CH-1:0]   zc_pulse,
  output logic              irq,
  input  logic              irq_ack,
  output logic [7:0]        irq_vec
);
  localparam int SEL_W = $clog2(N_CH);

  // internal events, named for the checker
  logic [N_CH-1:0]             trig_rise, trig_fall;
  logic [N_CH-1:0]             ch_irq_req, ch_run, ch_tc_pend, ch_ack;
  logic [N_CH-1:0][DATA_W-1:0] ch_count;
  logic [SEL_W-1:0]            arb_win;
  logic [7:0]                  vec_base_q;
  logic                        base_wr;

  qdt_trig_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_async(trig_in),
    .trig_rise(trig_rise), .trig_fall(trig_fall)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign ch_ack[g] = irq_ack && irq && (arb_win == IDX);
    qdt_channel #(.DATA_W(DATA_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(bus_we && (bus_sel == IDX)),
      .wr_byte(bus_wdata),
      .trig_rise(trig_rise[g]), .trig_fall(trig_fall[g]),
      .ack(ch_ack[g]),
      .count_o(ch_count[g]), .zc_o(zc_pulse[g]),
      .req_o(ch_irq_req[g]), .run_o(ch_run[g]), .tc_pend_o(ch_tc_pend[g])
    );
  end

  assign base_wr = bus_we && (bus_sel == '0) && !bus_wdata[0] && !ch_tc_pend[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_base_q <= '0;
    else if (base_wr) vec_base_q <= bus_wdata[7:0];
  end

  qdt_irq_arb #(.N_CH(N_CH), .SEL_W(SEL_W)) u_arb (
    .req(ch_irq_req), .base(vec_base_q),
    .irq(irq), .win(arb_win), .vec(irq_vec)
  );

  assign bus_rdata = ch_count[bus_sel];
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_we,
  input logic [1:0]                  bus_sel,
  input logic [N_CH-1:0]             zc_pulse,
  input logic                        irq,
  input logic                        irq_ack,
  input logic [7:0]                  irq_vec,
  input logic [N_CH-1:0]             ch_irq_req,
  input logic [N_CH-1:0]             ch_run,
  input logic [N_CH-1:0][DATA_W-1:0] ch_count
);
  AST_ZC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|zc_pulse) |=> ((zc_pulse & $past(zc_pulse)) == '0)) else $error("zc wider than one clock"); // R5

  AST_VEC_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ch_irq_req[irq_vec[2:1]]) else $error("vector names idle channel"); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> (!ch_irq_req[$past(irq_vec[2:1])] || zc_pulse[$past(irq_vec[2:1])])) else $error("ack kept request"); // R9

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [1:0] IDX = 2'(g);
    AST_REQ_FROM_ZC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_irq_req[g]) |-> zc_pulse[g]) else $error("request without terminal event"); // R9
    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_run[g] && !(bus_we && bus_sel == IDX)) |=> $stable(ch_count[g])) else $error("stopped count moved"); // R8
  end
endmodule

bind quad_down_timer qdt_checker #(.N_CH(N_CH), .DATA_W(DATA_W)) u_qdt_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
  .zc_pulse(zc_pulse), .irq(irq), .irq_ack(irq_ack), .irq_vec(irq_vec),
  .ch_irq_req(ch_irq_req), .ch_run(ch_run), .ch_count(ch_count)
);

// File: tb/tb_quad_down_timer.sv
module tb_quad_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {command, constant, edge count}
  localparam logic [25:0] VECS [NVEC] = '{
    {8'h57, 8'd5,   10'd3},
    {8'h57, 8'd5,   10'd5},
    {8'h57, 8'd5,   10'd12},
    {8'h47, 8'd3,   10'd7},
    {8'h57, 8'd1,   10'd4},
    {8'h57, 8'd0,   10'd3},
    {8'h57, 8'd0,   10'd256},
    {8'h47, 8'd200, 10'd450}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] tb_trig = '0;
  logic       chain_en = 1'b0;
  logic [3:0] trig_in, zc_pulse;
  logic       irq, irq_ack = 1'b0;
  logic [7:0] irq_vec;

  int n_chk = 0, n_fail = 0;
  int zc_tot [4];
  bit done = 1'b0;

  assign trig_in = {tb_trig[3:2], chain_en ? zc_pulse[0] : tb_trig[1], tb_trig[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_down_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .zc_pulse(zc_pulse), .irq(irq), .irq_ack(irq_ack), .irq_vec(irq_vec)
  );

  initial for (int i = 0; i < 4; i++) zc_tot[i] = 0;
  always @(negedge clk) if (rst_n) for (int i = 0; i < 4; i++) zc_tot[i] += int'(zc_pulse[i]);

  function automatic int span(input int tc);
    return (tc == 0) ? 256 : tc;
  endfunction
  function automatic int exp_count(input int tc, input int n);
    return ((n % span(tc)) == 0) ? tc : span(tc) - (n % span(tc));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    @(negedge clk);
    bus_sel = sel;
    #1 v = int'(bus_rdata);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); tb_trig[ch] = 1'b1;
    idle(3);        tb_trig[ch] = 1'b0;
    idle(3);
  endtask

  task automatic ack_once();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1;
  endtask

  // cycles between two successive terminal pulses of one channel
  task automatic period(input int ch, output int p);
    do @(negedge clk); while (!zc_pulse[ch]);
    p = 0;
    do begin @(negedge clk); p++; end while (!zc_pulse[ch]);
  endtask

  initial begin
    int v, v2, z0, p;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(2'(c), v); check("R1 count", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 zc", int'(zc_pulse), 0);
    check("R1 vec", int'(irq_vec), 0);

    // R4 R5 event counting on channel 2 from the vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(2'd2, VECS[k][25:18]);
      wr(2'd2, VECS[k][17:10]);
      idle(4);
      z0 = zc_tot[2];
      for (int e = 0; e < int'(VECS[k][9:0]); e++) pulse(2);
      idle(6);
      rd(2'd2, v);
      check("R4 count after edges", v, exp_count(int'(VECS[k][17:10]), int'(VECS[k][9:0])));
      check("R5 reload pulses", zc_tot[2] - z0, int'(VECS[k][9:0]) / span(int'(VECS[k][17:10])));
    end

    // R3 vector base and ignored non-command bytes
    wr(2'd0, 8'hA0);
    #1 check("R3 base shown", int'(irq_vec), 8'hA0);
    rd(2'd2, v);
    wr(2'd2, 8'h40);
    rd(2'd2, v2);
    check("R3 other channel count kept", v2, v);
    check("R3 other channel no base", int'(irq_vec), 8'hA0);

    // R9 requests, vector, priority, acknowledge
    wr(2'd3, 8'hD7); wr(2'd3, 8'd1);
    pulse(3); idle(4);
    check("R9 irq raised", int'(irq), 1);
    check("R9 vec ch3", int'(irq_vec), 8'hA6);
    wr(2'd1, 8'hD7); wr(2'd1, 8'd1);
    pulse(1); idle(4);
    check("R9 priority ch1", int'(irq_vec), 8'hA2);
    ack_once();
    check("R9 after ack vec", int'(irq_vec), 8'hA6);
    check("R9 after ack irq", int'(irq), 1);
    ack_once();
    check("R9 all cleared", int'(irq), 0);
    wr(2'd1, 8'h03); wr(2'd3, 8'h03);

    // R2 pending constant takes precedence over bit 0
    wr(2'd0, 8'h57); wr(2'd0, 8'h03);
    rd(2'd0, v); check("R2 odd byte as constant", v, 3);
    wr(2'd0, 8'h57); wr(2'd0, 8'h04);
    rd(2'd0, v); check("R2 even byte as constant", v, 4);
    check("R2 base untouched", int'(irq_vec), 8'hA0);
    wr(2'd0, 8'h03);

    // R10 cascade: interval ch0 (16*2) into event ch1 (3)
    chain_en = 1'b1;
    wr(2'd1, 8'h57); wr(2'd1, 8'd3);
    wr(2'd0, 8'h07); wr(2'd0, 8'd2);
    period(0, p); check("R6 ch0 period", p, 32);
    period(1, p); check("R10 cascade period", p, 96);
    wr(2'd0, 8'h03); wr(2'd1, 8'h03);
    idle(6);
    chain_en = 1'b0;

    // R6 interval prescales
    wr(2'd1, 8'h07); wr(2'd1, 8'd4);
    period(1, p); check("R6 div16 period", p, 64);
    wr(2'd1, 8'h27); wr(2'd1, 8'd2);
    period(1, p); check("R6 div256 period", p, 512);
    wr(2'd1, 8'h03);

    // R7 interval start on trigger
    wr(2'd3, 8'h1F); wr(2'd3, 8'd3);
    z0 = zc_tot[3];
    idle(100);
    rd(2'd3, v); check("R7 held before trigger", v, 3);
    check("R7 no pulse before trigger", zc_tot[3] - z0, 0);
    @(negedge clk); tb_trig[3] = 1'b1;
    idle(3); tb_trig[3] = 1'b0;
    idle(21);
    rd(2'd3, v); check("R7 started after trigger", v, 2);

    // R8 software stop freezes count
    wr(2'd3, 8'h03);
    rd(2'd3, v);
    z0 = zc_tot[3];
    idle(100);
    rd(2'd3, v2);
    check("R8 frozen count", v2, v);
    check("R8 no pulse while stopped", zc_tot[3] - z0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule